// File: doc/BRIEF.md
# Partitioned SIMD Add/Subtract and Logic Unit

This block is a 64-bit fixed-point arithmetic unit whose carry chain is broken at lane boundaries chosen on every operation. One pass adds or subtracts eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. The same datapath also performs bitwise logic, either across the full 64 bits or on the low 32 bits only.

The top holds one datapath per compute block (two by default). All of them take the same operation and lane-size command in a cycle, and each one works on its own operand pair. Results and per-lane status are registered and appear one cycle after the command is accepted. Each lane reports a carry-out bit and a signed-overflow bit. These flags are packed with the least-significant lane at bit 0 of an 8-bit vector for each block.

Top module: `lsa_dual`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `res`, `carry` and `ovf` are all zero after that edge, and they stay zero until an operation is accepted.
- R2: An operation is accepted at a rising edge where `in_valid` is 1. Its results appear after that edge with `out_valid` = 1. After an edge where `in_valid` is 0, `out_valid` is 0 and `res`, `carry` and `ovf` keep their previous values.
- R3: With `op` = 0 (add), each lane of width 8, 16, 32 or 64 (`size` = 0, 1, 2, 3) holds (a + b) mod 2^L. No carry enters a lane from the lane below it.
- R4: With `op` = 1 (subtract), each lane holds (a − b) mod 2^L, computed as a + ~b + 1 with the +1 injected at the bottom of every lane. No borrow crosses a lane boundary.
- R5: `carry` bit k (within a block's 8-bit field) is the carry-out of lane k of that block's a + b or a + ~b + 1. For subtract, 1 means no borrow occurred. Flag bits at positions equal to or above the lane count (8, 4, 2, 1 lanes for `size` 0..3) are 0.
- R6: `ovf` bit k is 1 exactly when lane k's two's-complement result overflowed: both addends (b inverted for subtract) have the same sign and the result's sign differs from it. Unused flag bits are 0.
- R7: With `size` = 3, the logic ops work on all 64 bits. The op codes are 2 = AND, 3 = OR, 4 = XOR and 5 = a AND NOT b.
- R8: With `size` = 0, 1 or 2, the logic ops work only on bits 31:0, and result bits 63:32 are 0. At any size, logic ops leave `carry` and `ovf` at 0.
- R9: Op codes 6 and 7 are reserved. An accepted reserved op produces a zero result and zero flags.
- R10: Block j uses operand slice j of `opa` and `opb` and drives slice j of `res`, `carry` and `ovf`. All blocks use the same `op` and `size`, and the data of one block does not affect the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation at this edge |
| op | input | 3 | Operation code (see R3, R4, R7, R9) |
| size | input | 2 | Lane width select: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| opa | input | NBLK*64 | First operands, block j in bits [64j+63:64j] |
| opb | input | NBLK*64 | Second operands, same packing |
| out_valid | output | 1 | Registered results belong to an accepted operation |
| res | output | NBLK*64 | Registered results, same packing as operands |
| carry | output | NBLK*8 | Per-lane carry-out, 8 bits per block, lane 0 lowest |
| ovf | output | NBLK*8 | Per-lane signed overflow, same packing |

## Verification
In one cycle a lane can raise its own carry-out and signed overflow while the lane directly above must still see no carry-in. Operand patterns such as 0x80 + 0x80 or 0x00 − 0x01 placed in every lane provoke this, and so does the all-ones + 1 pattern repeated across every lane size. The next lane's sum then shows whether a carry or borrow leaked through. Randomised commands mixed with these patterns are compared each cycle against a behavioural per-lane model, with different data in each block so that any coupling between blocks shows up.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int SEG_W = 8;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_ANDN = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } size_e;

  function automatic logic is_logic_op(op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR) || (o == OP_ANDN);
  endfunction
endpackage

// File: rtl/lsa_lane_map.sv
// Marks which segments start a lane for the selected lane width.
module lsa_lane_map
  import lsa_pkg::*;
#(
  parameter int NSEG = 8
) (
  input  size_e            size,
  output logic [NSEG-1:0]  seg_first
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_comb begin
      int span;
      span = 1 << int'(size);
      seg_first[i] = ((i % span) == 0);
    end
  end
endmodule

// File: rtl/lsa_seg_add.sv
// One segment of the carry chain with its own overflow detect.
module lsa_seg_add #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  output logic [SW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  logic [SW:0] wide;
  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{SW{1'b0}}, cin};
    sum  = wide[SW-1:0];
    cout = wide[SW];
    ovf  = (a[SW-1] == b[SW-1]) && (wide[SW-1] != a[SW-1]);
  end
endmodule

// File: rtl/lsa_unit.sv
// One compute block: segmented adder, logic ops, registered outputs.
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int DW = 64,
  parameter int SW = SEG_W,
  localparam int NSEG = DW / SW,
  localparam int HALF = DW / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  op_e             op,
  input  size_e           size,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  output logic [DW-1:0]   res,
  output logic [NSEG-1:0] cy,
  output logic [NSEG-1:0] ov
);
  logic            do_sub;
  logic [DW-1:0]   b_eff;
  logic [NSEG-1:0] seg_first;
  logic [NSEG-1:0] seg_cin, seg_cout, seg_ovf;
  logic [DW-1:0]   arith_sum;
  logic [DW-1:0]   logic_res;
  logic [DW-1:0]   res_d;
  logic [NSEG-1:0] cy_d, ov_d;

  assign do_sub = (op == OP_SUB);
  assign b_eff  = do_sub ? ~opb : opb;

  lsa_lane_map #(.NSEG(NSEG)) u_map (
    .size      (size),
    .seg_first (seg_first)
  );

  for (genvar s = 0; s < NSEG; s++) begin : g_chain
    if (s == 0) begin : g_bot
      assign seg_cin[s] = do_sub;
    end else begin : g_mid
      assign seg_cin[s] = seg_first[s] ? do_sub : seg_cout[s-1];
    end
    lsa_seg_add #(.SW(SW)) u_seg (
      .a    (opa[s*SW +: SW]),
      .b    (b_eff[s*SW +: SW]),
      .cin  (seg_cin[s]),
      .sum  (arith_sum[s*SW +: SW]),
      .cout (seg_cout[s]),
      .ovf  (seg_ovf[s])
    );
  end

  always_comb begin
    unique case (op)
      OP_AND:  logic_res = opa & opb;
      OP_OR:   logic_res = opa | opb;
      OP_XOR:  logic_res = opa ^ opb;
      OP_ANDN: logic_res = opa & ~opb;
      default: logic_res = '0;
    endcase
    if (size != SZ_64) logic_res[DW-1:HALF] = '0;
  end

  // Gather the flags of each lane's top segment, lane 0 at bit 0.
  always_comb begin
    int span, lanes, top;
    span  = 1 << int'(size);
    lanes = NSEG / span;
    cy_d  = '0;
    ov_d  = '0;
    for (int k = 0; k < NSEG; k++) begin
      top = (k + 1) * span - 1;
      if (k < lanes && top < NSEG && (op == OP_ADD || op == OP_SUB)) begin
        cy_d[k] = seg_cout[top];
        ov_d[k] = seg_ovf[top];
      end
    end
  end

  always_comb begin
    if (op == OP_ADD || op == OP_SUB) res_d = arith_sum;
    else if (is_logic_op(op))         res_d = logic_res;
    else                              res_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      cy  <= '0;
      ov  <= '0;
    end else if (in_valid) begin
      res <= res_d;
      cy  <= cy_d;
      ov  <= ov_d;
    end
  end

  // R8: narrow logic clears the upper half and raises no flags
  a_r8_logic_narrow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_logic_op(op) && size != SZ_64)
      |=> (res[DW-1:HALF] == '0) && (cy == '0) && (ov == '0));

  // R5/R6: 16-bit lanes leave the upper flag slots clear
  a_r5_unused_flags: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == SZ_16) |=> (cy[NSEG-1:NSEG/2] == '0) && (ov[NSEG-1:NSEG/2] == '0));

  // R2: outputs hold when nothing is accepted
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res) && $stable(cy) && $stable(ov));

  // R9: reserved codes give all-zero outputs
  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_RSV6 || op == OP_RSV7)) |=> (res == '0) && (cy == '0) && (ov == '0));

  // R6: a 64-bit lane can flag at most bit 0
  a_r6_single_lane: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == SZ_64) |=> $countones(ov) <= 1 && $onehot0(cy));
endmodule

// File: rtl/lsa_dual.sv
// Several compute blocks sharing one command.
module lsa_dual
  import lsa_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NBLK = 2,
  localparam int NSEG = DW / SEG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic [1:0]           size,
  input  logic [NBLK*DW-1:0]   opa,
  input  logic [NBLK*DW-1:0]   opb,
  output logic                 out_valid,
  output logic [NBLK*DW-1:0]   res,
  output logic [NBLK*NSEG-1:0] carry,
  output logic [NBLK*NSEG-1:0] ovf
);
  op_e   op_q;
  size_e size_q;
  assign op_q   = op_e'(op);
  assign size_q = size_e'(size);

  for (genvar j = 0; j < NBLK; j++) begin : g_blk
    lsa_unit #(.DW(DW), .SW(SEG_W)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .op       (op_q),
      .size     (size_q),
      .opa      (opa[j*DW +: DW]),
      .opb      (opb[j*DW +: DW]),
      .res      (res[j*DW +: DW]),
      .cy       (carry[j*NSEG +: NSEG]),
      .ov       (ovf[j*NSEG +: NSEG])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R2: valid follows acceptance by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R1: reset clears valid
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/lsa_dual_test.sv
module lsa_dual_test;
  localparam int DW = 64;
  localparam int NBLK = 2;
  localparam int NSEG = 8;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [2:0] op = 0;
  logic [1:0] size = 0;
  logic [NBLK*DW-1:0] opa = '0, opb = '0;
  logic out_valid;
  logic [NBLK*DW-1:0] res;
  logic [NBLK*NSEG-1:0] carry, ovf;

  always #2 clk = ~clk;

  lsa_dual #(.DW(DW), .NBLK(NBLK)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .opa(opa), .opb(opb), .out_valid(out_valid), .res(res),
    .carry(carry), .ovf(ovf)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural expectation
  logic               m_valid = 0;
  logic [DW-1:0]      m_res [NBLK];
  logic [NSEG-1:0]    m_cy  [NBLK];
  logic [NSEG-1:0]    m_ov  [NBLK];
  logic [2:0]         m_op  = 0;
  logic [1:0]         m_sz  = 0;
  bit                 m_rst = 1;

  function automatic void model(input logic [2:0] o, input logic [1:0] s,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output logic [7:0] c,
                                output logic [7:0] v);
    int lw, n;
    logic [64:0] msk, al, bl, sm;
    r = '0; c = '0; v = '0;
    if (o <= 3'd1) begin
      lw = 8 << s;
      n  = 64 / lw;
      msk = (65'd1 << lw) - 65'd1;
      for (int k = 0; k < n; k++) begin
        al = ({1'b0, a} >> (k * lw)) & msk;
        bl = ({1'b0, b} >> (k * lw)) & msk;
        if (o == 3'd1) bl = (~bl) & msk;
        sm = al + bl + ((o == 3'd1) ? 65'd1 : 65'd0);
        r  = r | (64'((sm & msk)) << (k * lw));
        c[k] = sm[lw];
        v[k] = (al[lw-1] == bl[lw-1]) && (sm[lw-1] != al[lw-1]);
      end
    end else if (o <= 3'd5) begin
      case (o)
        3'd2: r = a & b;
        3'd3: r = a | b;
        3'd4: r = a ^ b;
        default: r = a & ~b;
      endcase
      if (s != 2'd3) r[63:32] = '0;
    end
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    m_rst <= rst;
    if (rst) begin
      m_valid <= 0;
      for (int j = 0; j < NBLK; j++) begin
        m_res[j] <= '0; m_cy[j] <= '0; m_ov[j] <= '0;
      end
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_op <= op; m_sz <= size;
        for (int j = 0; j < NBLK; j++) begin
          logic [63:0] r; logic [7:0] c, v;
          model(op, size, opa[j*DW +: DW], opb[j*DW +: DW], r, c, v);
          m_res[j] <= r; m_cy[j] <= c; m_ov[j] <= v;
        end
      end
    end
  end

  function automatic string res_req(input logic [2:0] o, input logic [1:0] s);
    if (o == 3'd0) return "R3";
    if (o == 3'd1) return "R4";
    if (o >= 3'd6) return "R9";
    return (s == 2'd3) ? "R7" : "R8";
  endfunction

  task automatic compare();
    string pre;
    pre = m_rst ? "R1 " : "";
    checks++;
    if (out_valid !== m_valid) begin
      errors++;
      $display("FAIL %sR2 out_valid got %0b exp %0b", pre, out_valid, m_valid);
    end
    for (int j = 0; j < NBLK; j++) begin
      string blk;
      blk = (j > 0) ? " R10" : "";
      checks++;
      if (res[j*DW +: DW] !== m_res[j]) begin
        errors++;
        $display("FAIL %s%s%s blk%0d res got %h exp %h", pre, res_req(m_op, m_sz), blk, j,
                 res[j*DW +: DW], m_res[j]);
      end
      checks++;
      if (carry[j*NSEG +: NSEG] !== m_cy[j]) begin
        errors++;
        $display("FAIL %sR5%s blk%0d carry got %b exp %b", pre, blk, j,
                 carry[j*NSEG +: NSEG], m_cy[j]);
      end
      checks++;
      if (ovf[j*NSEG +: NSEG] !== m_ov[j]) begin
        errors++;
        $display("FAIL %sR6%s blk%0d ovf got %b exp %b", pre, blk, j,
                 ovf[j*NSEG +: NSEG], m_ov[j]);
      end
    end
  endtask

  task automatic drive(input bit v, input logic [2:0] o, input logic [1:0] s,
                       input logic [63:0] ax, input logic [63:0] bx,
                       input logic [63:0] ay, input logic [63:0] by);
    @(negedge clk);
    compare();
    in_valid = v; op = o; size = s;
    opa = {ay, ax}; opb = {by, bx};
  endtask

  initial begin
    // R1: operation requested during reset must not show up
    drive(1, 3'd0, 2'd0, 64'hFFFF, 64'h1, 64'h5, 64'h6);
    drive(1, 3'd2, 2'd3, '1, '1, '1, '1);
    rst = 0;
    drive(0, 3'd0, 2'd0, 0, 0, 0, 0);
    // R3/R5/R6: carry and overflow in every lane, no leak
    for (int s = 0; s < 4; s++) begin
      drive(1, 3'd0, 2'(s), '1, 64'h0101_0101_0101_0101, 64'h8080_8080_8080_8080,
            64'h8080_8080_8080_8080);
      drive(1, 3'd0, 2'(s), 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, '1, 64'h1);
      // R4: borrow isolation
      drive(1, 3'd1, 2'(s), 64'h0, 64'h0101_0101_0101_0101, 64'h8000_0000_8000_0000, 64'h1);
      drive(1, 3'd1, 2'(s), 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0);
    end
    // R7/R8/R9: logic widths and reserved codes
    for (int o = 2; o < 8; o++) begin
      drive(1, 3'(o), 2'd3, 64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FFFF_0F0F, '1, 64'h3);
      drive(1, 3'(o), 2'd1, 64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FFFF_0F0F, '1, 64'h3);
    end
    // R2: idle cycles hold
    drive(0, 3'd0, 2'd0, '1, '1, '1, '1);
    drive(0, 3'd1, 2'd3, 0, 5, 0, 5);
    // randomised mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ax, bx, ay, by;
      ax = {$urandom, $urandom}; bx = {$urandom, $urandom};
      ay = {$urandom, $urandom}; by = {$urandom, $urandom};
      if (($urandom % 4) == 0) bx = ~ax;
      drive(($urandom % 5) != 0, 3'($urandom % 8), 2'($urandom % 4), ax, bx, ay, by);
    end
    // R1: reset in mid stream
    rst = 1;
    drive(1, 3'd0, 2'd0, 5, 5, 5, 5);
    rst = 0;
    drive(0, 3'd0, 2'd0, 0, 0, 0, 0);
    drive(0, 3'd0, 2'd0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles exp completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule